// File: doc/BRIEF.md
# SMBus Indexed Block Register Slave

This block is a slave on a two-wire SMBus. It gives a host access to a small byte-addressed register file through indexed block transfers. SCL and SDA are sampled with a fast system clock. Each line goes through a synchronizer and a glitch filter. The engine then decodes START, repeated START and STOP from the filtered levels. SDA is open drain: the block only ever pulls the line low, through `sda_oe`.

A write carries a start index, then a byte count, then the data bytes. A read first sets the index with a write header. A repeated START with the read address follows. The slave then returns a count byte, which comes from a host-programmable register. The data bytes from the index onward follow the count byte. The register file holds read/write control bytes, two read-only identification bytes and the read-back count register.

Top module: `smb_regslave`

## Requirements
- R1: The slave answers only address byte D2h (write) and D3h (read), which is 7-bit address 69h with R/W in bit 0. Any other address byte gets no ACK, and the bytes after it up to the next START or STOP get no ACK and change nothing.
- R2: A block write (START, D2h, index N, count X, X data bytes, STOP) stores the data at N through N+X-1 and ACKs every byte.
- R3: A data byte sent after X bytes have already been stored gets no ACK and is not stored. A count of 0 stores nothing.
- R4: A block read (START, D2h, N, repeated START, D3h) returns the count byte first. The bytes at N, N+1, … follow for as long as the host ACKs. A host NACK ends the transfer and leaves SDA released.
- R5: Index 8 is the read-back count. It is read/write, resets to 09h, and a read does not change it.
- R6: Index 6 reads 13h and index 7 reads 01h (revision 0 in bits 7:4, vendor 1 in bits 3:0). Writes to them are ACKed and change nothing.
- R7: Indices 10 and above read 00h. Writes to them are ACKed and ignored.
- R8: A STOP or START in the middle of a byte abandons the transfer, and the partial byte is not stored. A START begins a new address phase.
- R9: `sda_oe` changes only while SCL is low.
- R10: After reset `sda_oe` is 0 and the read/write indices 0–5 and 9 hold 00h.
- R11: Pulses on SCL or SDA shorter than GLITCH system clocks are ignored. They add no bit and are not taken as a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Some rules are checked on every cycle. `sda_oe` moves only while the filtered SCL is low. The line is released after reset and whenever the engine is idle. Every committed write is followed by an ACK drive. The count register changes only through a write to index 8. The bench scenarios cover the rest, which needs whole transactions. These are the index and count handling, auto-increment on both directions, NACK of surplus bytes, read-only and unimplemented locations, transfers cut off by START or STOP, and glitches on both lines.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam logic [6:0] SLV_ADDR   = 7'h69;
  localparam int         NREG_DEF   = 10;
  localparam int         IDX_DEVID  = 6;
  localparam int         IDX_REVVEN = 7;
  localparam int         IDX_COUNT  = 8;
  localparam logic [7:0] DEVID_VAL  = 8'h13;
  localparam logic [7:0] REVVEN_VAL = 8'h01;
  localparam logic [7:0] COUNT_RST  = 8'h09;

  typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_RXACK, PH_TX, PH_TXACK} phase_t;
  typedef enum logic [1:0] {RL_ADDR, RL_INDEX, RL_COUNT, RL_DATA} role_t;
endpackage

// File: rtl/smb_glitch.sv
module smb_glitch #(
  parameter int GLITCH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(GLITCH + 1);
  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      filt <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == filt) begin
        cnt <= '0;
      end else if (cnt == CW'(GLITCH - 1)) begin
        filt <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_cond.sv
module smb_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign start_det = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile import smb_pkg::*; #(
  parameter int NREG = NREG_DEF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_data,
  output logic [7:0] cnt_q
);
  localparam int IW = $clog2(NREG);
  logic [NREG-1:0][7:0] regs;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == IDX_DEVID) begin : g_devid
      assign regs[i] = DEVID_VAL;
    end else if (i == IDX_REVVEN) begin : g_revven
      assign regs[i] = REVVEN_VAL;
    end else begin : g_rw
      localparam logic [7:0] RSTV = (i == IDX_COUNT) ? COUNT_RST : 8'h00;
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= RSTV;
        else if (wr_en && wr_idx == 8'(i)) q <= wr_data;
      end
      assign regs[i] = q;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_idx < 8'(NREG)) rd_data = regs[rd_idx[IW-1:0]];
  end

  assign cnt_q = regs[IDX_COUNT];
endmodule

// File: rtl/smb_engine.sv
module smb_engine import smb_pkg::*; #(
  parameter logic [6:0] ADDR = SLV_ADDR
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_f,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  input  logic [7:0] cnt_q,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx,
  output logic       idle,
  output logic       sda_oe
);
  phase_t     ph;
  role_t      role;
  logic [7:0] sh, ptr, remain;
  logic [3:0] bitcnt;
  logic       go_tx, host_ack;
  logic       bus_evt, byte_done;

  assign bus_evt   = start_det | stop_det;
  assign byte_done = !bus_evt && ph == PH_RX && scl_fall && bitcnt == 4'd8;
  assign wr_en     = byte_done && role == RL_DATA && remain != 8'd0;
  assign wr_idx    = ptr;
  assign wr_data   = sh;
  assign rd_idx    = ptr;
  assign idle      = (ph == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      role     <= RL_ADDR;
      sh       <= '0;
      ptr      <= '0;
      remain   <= '0;
      bitcnt   <= '0;
      go_tx    <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (stop_det) begin
      ph     <= PH_IDLE;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      ph     <= PH_RX;
      role   <= RL_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (ph)
        PH_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            sh     <= {sh[6:0], sda_f};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            go_tx <= 1'b0;
            unique case (role)
              RL_ADDR: begin
                if (sh[7:1] == ADDR) begin
                  go_tx  <= sh[0];
                  role   <= RL_INDEX;
                  sda_oe <= 1'b1;
                  ph     <= PH_RXACK;
                end else begin
                  ph <= PH_IDLE;
                end
              end
              RL_INDEX: begin
                ptr    <= sh;
                role   <= RL_COUNT;
                sda_oe <= 1'b1;
                ph     <= PH_RXACK;
              end
              RL_COUNT: begin
                remain <= sh;
                role   <= RL_DATA;
                sda_oe <= 1'b1;
                ph     <= PH_RXACK;
              end
              RL_DATA: begin
                if (remain != 8'd0) begin
                  ptr    <= ptr + 1'b1;
                  remain <= remain - 1'b1;
                  sda_oe <= 1'b1;
                  ph     <= PH_RXACK;
                end else begin
                  ph <= PH_IDLE;
                end
              end
              default: ph <= PH_IDLE;
            endcase
          end
        end
        PH_RXACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (go_tx) begin
              sh     <= cnt_q;
              sda_oe <= ~cnt_q[7];
              ph     <= PH_TX;
            end else begin
              sda_oe <= 1'b0;
              ph     <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              ph     <= PH_TXACK;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        PH_TXACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_f;
          end else if (scl_fall) begin
            if (host_ack) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[7];
              ptr    <= ptr + 1'b1;
              bitcnt <= '0;
              ph     <= PH_TX;
            end else begin
              ph <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave import smb_pkg::*; #(
  parameter logic [6:0] ADDR   = SLV_ADDR,
  parameter int         NREG   = NREG_DEF,
  parameter int         GLITCH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int NLINE = 2;
  logic [NLINE-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, in_idle;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data, cnt_q;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    smb_glitch #(.GLITCH(GLITCH)) u_flt (
      .clk(clk), .rst(rst), .raw(raw_lines[g]), .filt(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  smb_cond u_cond (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_engine #(.ADDR(ADDR)) u_eng (
    .clk(clk), .rst(rst), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .cnt_q(cnt_q),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
    .idle(in_idle), .sda_oe(sda_oe)
  );

  smb_regfile #(.NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .cnt_q(cnt_q)
  );
endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk import smb_pkg::*; (
  input logic       clk,
  input logic       rst,
  input logic       sda_oe,
  input logic       scl_f,
  input logic       in_idle,
  input logic       wr_en,
  input logic [7:0] wr_idx,
  input logic [7:0] cnt_q
);
  // R9: the drive moves only while the filtered clock is low
  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_f);

  // R10: reset releases the line
  a_r10_reset_release: assert property (@(posedge clk)
    rst |=> !sda_oe);

  // R1: an idle engine never holds SDA
  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    in_idle |-> !sda_oe);

  // R2: every committed byte is acknowledged
  a_r2_write_acked: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> sda_oe);

  // R5: the count register moves only on a write to index 8
  a_r5_count_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == 8'(IDX_COUNT)) |=> $stable(cnt_q));
endmodule

bind smb_regslave smb_regslave_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_f(scl_f), .in_idle(in_idle),
  .wr_en(wr_en), .wr_idx(wr_idx), .cnt_q(cnt_q)
);

// File: tb/sim_smb_regslave.sv
module sim_smb_regslave;
  localparam int H = 12;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_h = 1'b1;
  logic sda_low = 1'b0;
  logic sda_oe;
  wire  sda_line = !(sda_low || sda_oe);
  int   checks = 0, fails = 0, viol = 0;
  bit   done = 1'b0;
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;

  smb_regslave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  // R9 monitor: drive changes must fall inside a low SCL phase
  always @(negedge clk) begin
    if (!rst && sda_oe !== prev_oe && scl_h) viol++;
    prev_oe = sda_oe;
  end

  // index, write data, expected read-back
  localparam logic [23:0] VEC [8] = '{
    24'h00A5A5, 24'h053C3C, 24'h097E7E, 24'h06FF13,
    24'h070001, 24'h0A5500, 24'hC8AA00, 24'h038181
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic qtr();
    repeat (H/2) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_low = 1'b0; half(); scl_h = 1'b1; half();
    sda_low = 1'b1; half(); scl_h = 1'b0; qtr();
  endtask

  task automatic bus_stop();
    sda_low = 1'b1; half(); scl_h = 1'b1; half(); sda_low = 1'b0; half();
  endtask

  // gl bit0: SCL glitch in the low phase, bit1: SDA glitch in the high phase
  task automatic clk_bit(input logic b, input int gl, output logic r);
    sda_low = !b; half(); scl_h = 1'b1; qtr();
    if (gl[1]) begin
      sda_low = 1'b1; @(negedge clk); sda_low = !b;
    end
    qtr(); r = sda_line; scl_h = 1'b0; qtr();
    if (gl[0]) begin
      scl_h = 1'b1; @(negedge clk); scl_h = 1'b0; @(negedge clk);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, input int gl, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], (i == 7) ? gl : 0, r);
    clk_bit(1'b1, 0, r);
    ack = !r;
  endtask

  task automatic rd_byte(input logic ackit, output logic [7:0] b);
    logic r;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, 0, r);
      b = {b[6:0], r};
    end
    clk_bit(!ackit, 0, r);
  endtask

  task automatic blk_write(input logic [7:0] idx, input logic [7:0] cnt,
                           input logic [31:0] data, input int n, input int gl,
                           output logic [7:0] acks);
    logic a;
    acks = '0;
    bus_start();
    wr_byte(8'hD2, 0, a); acks[0] = a;
    wr_byte(idx, 0, a);   acks[1] = a;
    wr_byte(cnt, 0, a);   acks[2] = a;
    for (int k = 0; k < n; k++) begin
      wr_byte(data[31-8*k -: 8], gl, a);
      acks[3+k] = a;
    end
    bus_stop();
  endtask

  task automatic blk_read(input logic [7:0] idx, input int n,
                          output logic [7:0] cnt, output logic [31:0] d,
                          output logic ok);
    logic a0, a1, a2;
    logic [7:0] b;
    bus_start();
    wr_byte(8'hD2, 0, a0);
    wr_byte(idx, 0, a1);
    bus_start();
    wr_byte(8'hD3, 0, a2);
    rd_byte(1'b1, cnt);
    d = '0;
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, b);
      d = {d[23:0], b};
    end
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] acks, c;
    logic [31:0] d;
    logic ok, a;
    string tag;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk("R10 sda_oe after reset", {31'd0, sda_oe}, 32'd0);
    blk_read(8'h00, 1, c, d, ok);
    chk("R5 count reset 09h", {24'd0, c}, 32'h09);
    chk("R10 index 0 reset", d, 32'h00);
    blk_read(8'h09, 1, c, d, ok);
    chk("R10 index 9 reset", d, 32'h00);

    // vector table: single-byte writes and read-back
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][23:16] == 8'h06 || VEC[i][23:16] == 8'h07) tag = "R6";
      else if (VEC[i][23:16] >= 8'h0A) tag = "R7";
      else tag = "R2";
      blk_write(VEC[i][23:16], 8'd1, {VEC[i][15:8], 24'd0}, 1, 0, acks);
      chk({tag, " write acks"}, {24'd0, acks}, 32'h0F);
      blk_read(VEC[i][23:16], 1, c, d, ok);
      chk({tag, " read header acked"}, {31'd0, ok}, 32'd1);
      chk({tag, " count byte"}, {24'd0, c}, 32'h09);
      chk({tag, " read-back"}, d, {24'd0, VEC[i][7:0]});
    end

    // R2 multi-byte write, R4 auto-increment on read
    blk_write(8'h01, 8'd3, 32'h11223300, 3, 0, acks);
    chk("R2 three-byte write acks", {24'd0, acks}, 32'h3F);
    blk_read(8'h01, 3, c, d, ok);
    chk("R2 three-byte read-back", d, 32'h00112233);
    blk_read(8'h00, 4, c, d, ok);
    chk("R4 four-byte read from 0", d, 32'hA5112233);
    chk("R4 released after NACK", {31'd0, sda_oe}, 32'd0);

    // R3 surplus data and zero count
    blk_write(8'h02, 8'd1, 32'h44550000, 2, 0, acks);
    chk("R3 surplus byte NACK", {24'd0, acks}, 32'h0F);
    blk_read(8'h02, 2, c, d, ok);
    chk("R3 surplus not stored", d, 32'h00004433);
    blk_write(8'h04, 8'd0, 32'h66000000, 1, 0, acks);
    chk("R3 zero count NACK", {24'd0, acks}, 32'h07);
    blk_read(8'h04, 1, c, d, ok);
    chk("R3 zero count stores nothing", d, 32'h00);

    // R5 programmable count
    blk_write(8'h08, 8'd1, 32'h04000000, 1, 0, acks);
    blk_read(8'h00, 1, c, d, ok);
    chk("R5 count after write", {24'd0, c}, 32'h04);
    blk_read(8'h00, 1, c, d, ok);
    chk("R5 count unchanged by read", {24'd0, c}, 32'h04);
    blk_write(8'h08, 8'd1, 32'h09000000, 1, 0, acks);

    // R1 foreign address
    acks = '0;
    bus_start();
    wr_byte(8'hA0, 0, a); acks[0] = a;
    wr_byte(8'h00, 0, a); acks[1] = a;
    wr_byte(8'h01, 0, a); acks[2] = a;
    wr_byte(8'h77, 0, a); acks[3] = a;
    bus_stop();
    chk("R1 foreign address unanswered", {24'd0, acks}, 32'h00);
    blk_read(8'h00, 1, c, d, ok);
    chk("R1 foreign write ignored", d, 32'hA5);

    // R8 STOP inside a data byte
    bus_start();
    wr_byte(8'hD2, 0, a); wr_byte(8'h00, 0, a); wr_byte(8'h01, 0, a);
    for (int k = 0; k < 4; k++) clk_bit(1'b1, 0, a);
    bus_stop();
    blk_read(8'h00, 1, c, d, ok);
    chk("R8 STOP abort keeps index 0", d, 32'hA5);

    // R8 START inside a data byte, then a new transfer
    bus_start();
    wr_byte(8'hD2, 0, a); wr_byte(8'h05, 0, a); wr_byte(8'h01, 0, a);
    for (int k = 0; k < 3; k++) clk_bit(1'b0, 0, a);
    bus_start();
    acks = '0;
    wr_byte(8'hD2, 0, a); acks[0] = a;
    wr_byte(8'h09, 0, a); acks[1] = a;
    wr_byte(8'h01, 0, a); acks[2] = a;
    wr_byte(8'h5A, 0, a); acks[3] = a;
    bus_stop();
    chk("R8 restart transfer acks", {24'd0, acks}, 32'h0F);
    blk_read(8'h05, 1, c, d, ok);
    chk("R8 START abort keeps index 5", d, 32'h3C);
    blk_read(8'h09, 1, c, d, ok);
    chk("R8 restarted write stored", d, 32'h5A);

    // R11 glitches on both lines
    blk_write(8'h00, 8'd1, 32'hC3000000, 1, 3, acks);
    chk("R11 glitched write acks", {24'd0, acks}, 32'h0F);
    blk_read(8'h00, 1, c, d, ok);
    chk("R11 glitched write data", d, 32'hC3);

    chk("R9 drive changes during SCL low", viol, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule